// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a single-cycle execution unit for fixed-width integer add and subtract. It takes two operands that have already been read from a register file, plus a 2-bit operation code and two recording controls. On the clock edge where `op_valid` is high, it registers the result and raises `res_valid` for one cycle. On that same edge it updates a small set of architectural flags: a carry bit, an overflow bit, a sticky summary-overflow bit and a 4-bit condition field.

There are four operation forms:
- a plain add;
- an add that records its carry;
- an extended add, which adds in the carry left by an earlier operation;
- a subtract.

`rec_ov` chooses whether signed overflow is recorded. `rec_cr` chooses whether the condition field is rewritten. The condition field classifies the result as negative, positive or zero, and carries a copy of the sticky overflow bit.

Top module: `addflag_unit`

## Requirements
- R1: One cycle after an accepted operation, `res_data` holds the operation's result and `res_valid` is 1. The codes are: 0 = a+b, 1 = a+b recording carry, 2 = a+b+carry, 3 = a-b. All arithmetic wraps modulo 2^WIDTH.
- R2: With `rec_cr`=1, `cr_q` bits [3:1] receive exactly one set bit. Bit 3 (LT) is set when the result's top bit is 1. Bit 2 (GT) is set for a non-zero result whose top bit is 0. Bit 1 (EQ) is set for a zero result.
- R3: With `rec_cr`=1, `cr_q[0]` equals the sticky overflow value that results from the same operation, including any overflow that operation itself records.
- R4: For an add form with `rec_ov`=1, signed overflow occurs when both operands have the same sign and the result's sign differs. When it occurs, `ov_q` and `so_q` both become 1.
- R5: For a subtract with `rec_ov`=1, signed overflow occurs when the operand signs differ and the result's sign differs from a's sign. When it occurs, `ov_q` and `so_q` both become 1.
- R6: With `rec_ov`=1 and no overflow, `ov_q` is cleared and `so_q` keeps its value.
- R7: With `rec_ov`=0, `ov_q` and `so_q` are unchanged. With `rec_cr`=0, `cr_q` is unchanged.
- R8: Code 1 sets `ca_q` to the unsigned carry out of a+b. Codes 0 and 3 leave `ca_q` unchanged.
- R9: Code 2 adds the stored `ca_q` and then sets `ca_q` to the carry out of a+b+carry. This covers the case where b plus the carry alone wraps.
- R10: A synchronous reset clears `ca_q`, `ov_q`, `so_q`, `cr_q` and `res_valid`.
- R11: In a cycle without `op_valid`, `res_valid` is 0 on the next cycle and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Accept an operation this cycle |
| op_code | input | 2 | Operation form (0 add, 1 add-carry, 2 extended add, 3 subtract) |
| rec_ov | input | 1 | Record signed overflow |
| rec_cr | input | 1 | Rewrite the condition field |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| res_valid | output | 1 | Result strobe, one cycle after acceptance |
| res_data | output | WIDTH | Registered result |
| ca_q | output | 1 | Stored carry |
| ov_q | output | 1 | Overflow of the last recording operation |
| so_q | output | 1 | Sticky summary overflow |
| cr_q | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The hardest case is the extended add where b plus the stored carry wraps by itself, so that a+b on its own would produce no carry. Reaching it needs a carry-recording add to leave `ca_q` at 1 first. The stimulus then issues code 2 with b all-ones and a zero. A second hard case is the condition field's SO copy on the same operation that first sets the sticky bit. The bench issues an overflowing add with both `rec_ov` and `rec_cr` from a clean state and expects `cr_q[0]` to be 1 at once. It then clears OV with a non-overflowing operation to show that SO stays set.

// File: rtl/addflag_pkg.sv
package addflag_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_ADDE = 2'd2,
    OP_SUB  = 2'd3
  } addop_e;

  localparam int CR_W  = 4;
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;

endpackage

// File: rtl/addflag_arith.sv
module addflag_arith
  import addflag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  addop_e           op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ca_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_evt,
  output logic             ovf_evt,
  output logic             ca_write
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] fn_result(addop_e o, logic [WIDTH-1:0] x,
                                                 logic [WIDTH-1:0] y, logic c);
    logic [WIDTH-1:0] r;
    case (o)
      OP_SUB:  r = x - y;
      OP_ADDE: r = x + y + {{(WIDTH-1){1'b0}}, c};
      default: r = x + y;
    endcase
    return r;
  endfunction

  function automatic logic fn_carry(addop_e o, logic [WIDTH-1:0] x,
                                    logic [WIDTH-1:0] y, logic c, logic [WIDTH-1:0] r);
    logic [WIDTH-1:0] yc;
    logic cy;
    yc = y + {{(WIDTH-1){1'b0}}, c};
    case (o)
      OP_ADDC: cy = (r < x);
      OP_ADDE: cy = (yc < y) || (r < x);
      default: cy = 1'b0;
    endcase
    return cy;
  endfunction

  function automatic logic fn_ovf(addop_e o, logic [WIDTH-1:0] x,
                                  logic [WIDTH-1:0] y, logic [WIDTH-1:0] r);
    logic [WIDTH-1:0] t;
    if (o == OP_SUB) t = (x ^ y) & (x ^ r);
    else             t = ~(x ^ y) & (x ^ r);
    return t[MSB];
  endfunction

  always_comb begin
    sum       = fn_result(op, a, b, ca_in);
    carry_evt = fn_carry(op, a, b, ca_in, sum);
    ovf_evt   = fn_ovf(op, a, b, sum);
    ca_write  = (op == OP_ADDC) || (op == OP_ADDE);
  end

endmodule

// File: rtl/addflag_cond.sv
module addflag_cond
  import addflag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] r,
  input  logic             so_in,
  output logic [CR_W-1:0]  cr_new
);

  logic neg_evt;
  logic zero_evt;

  always_comb begin
    neg_evt  = r[WIDTH-1];
    zero_evt = (r == '0);
    cr_new         = '0;
    cr_new[CR_LT]  = neg_evt;
    cr_new[CR_GT]  = !neg_evt && !zero_evt;
    cr_new[CR_EQ]  = zero_evt;
    cr_new[CR_SO]  = so_in;
  end

endmodule

// File: rtl/addflag_flags.sv
module addflag_flags
  import addflag_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  addop_e          op,
  input  logic            rec_ov,
  input  logic            rec_cr,
  input  logic            carry_evt,
  input  logic            ca_write,
  input  logic            ovf_evt,
  input  logic [CR_W-1:0] cr_new,
  output logic            so_next,
  output logic            ca_q,
  output logic            ov_q,
  output logic            so_q,
  output logic [CR_W-1:0] cr_q
);

  logic ov_wr;
  logic cr_wr;
  logic ca_wr;

  assign ov_wr   = fire && rec_ov;
  assign cr_wr   = fire && rec_cr;
  assign ca_wr   = fire && ca_write;
  assign so_next = so_q || (ov_wr && ovf_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ca_q <= 1'b0;
      ov_q <= 1'b0;
      so_q <= 1'b0;
      cr_q <= '0;
    end else begin
      if (ca_wr) ca_q <= carry_evt;
      if (ov_wr) begin
        ov_q <= ovf_evt;
        so_q <= so_next;
      end
      if (cr_wr) cr_q <= cr_new;
    end
  end

  // R2
  cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cr_wr)) |-> ($countones(cr_q[CR_LT:CR_EQ]) == 1));

  // R3
  cr_so_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cr_wr)) |-> (cr_q[CR_SO] == so_q));

  // R4
  ovf_sets_so_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ov_wr && ovf_evt)) |-> (ov_q && so_q));

  // R6
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(so_q)) |-> so_q);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!ov_wr)) |-> ($stable(ov_q) && $stable(so_q)));

  // R7
  no_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!cr_wr)) |-> $stable(cr_q));

  // R8
  ca_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!fire || op == OP_ADD || op == OP_SUB)) |-> $stable(ca_q));

endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
  import addflag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic             rec_ov,
  input  logic             rec_cr,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             ca_q,
  output logic             ov_q,
  output logic             so_q,
  output logic [3:0]       cr_q
);

  addop_e           op;
  logic [WIDTH-1:0] sum;
  logic             carry_evt;
  logic             ovf_evt;
  logic             ca_write;
  logic             so_next;
  logic [CR_W-1:0]  cr_new;

  assign op = addop_e'(op_code);

  addflag_arith #(.WIDTH(WIDTH)) u_arith (
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .ca_in     (ca_q),
    .sum       (sum),
    .carry_evt (carry_evt),
    .ovf_evt   (ovf_evt),
    .ca_write  (ca_write)
  );

  addflag_cond #(.WIDTH(WIDTH)) u_cond (
    .r      (sum),
    .so_in  (so_next),
    .cr_new (cr_new)
  );

  addflag_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .fire      (op_valid),
    .op        (op),
    .rec_ov    (rec_ov),
    .rec_cr    (rec_cr),
    .carry_evt (carry_evt),
    .ca_write  (ca_write),
    .ovf_evt   (ovf_evt),
    .cr_new    (cr_new),
    .so_next   (so_next),
    .ca_q      (ca_q),
    .ov_q      (ov_q),
    .so_q      (so_q),
    .cr_q      (cr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= sum;
    end
  end

  // R1
  res_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(op_valid)));

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid)) |-> $stable(res_data));

endmodule

// File: tb/tb_addflag_unit.sv
module tb_addflag_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [1:0]   op_code = 2'd0;
  logic         rec_ov = 1'b0;
  logic         rec_cr = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         res_valid;
  logic [W-1:0] res_data;
  logic         ca_q, ov_q, so_q;
  logic [3:0]   cr_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic       e_ca = 0, e_ov = 0, e_so = 0;
  logic [3:0] e_cr = 0;

  always #10 clk = ~clk;

  addflag_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .rec_ov(rec_ov), .rec_cr(rec_cr), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_data(res_data), .ca_q(ca_q), .ov_q(ov_q),
    .so_q(so_q), .cr_q(cr_q)
  );

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_flags(string tag);
    check(tag, "ca", {31'd0, ca_q}, {31'd0, e_ca});
    check(tag, "ov", {31'd0, ov_q}, {31'd0, e_ov});
    check(tag, "so", {31'd0, so_q}, {31'd0, e_so});
    check(tag, "cr", {28'd0, cr_q}, {28'd0, e_cr});
  endtask

  // Issue one operation, update the reference model, check result and flags.
  task automatic do_op(string tag, logic [1:0] code, logic rov, logic rcr,
                       logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         ovf;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; rec_ov = rov; rec_cr = rcr;
    opnd_a = a; opnd_b = b;
    case (code)
      2'd3:    wide = {1'b0, a} - {1'b0, b};
      2'd2:    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, e_ca};
      default: wide = {1'b0, a} + {1'b0, b};
    endcase
    r = wide[W-1:0];
    if (code == 2'd3) ovf = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    else              ovf = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    if (code == 2'd1 || code == 2'd2) e_ca = wide[W];
    if (rov) begin
      e_ov = ovf;
      if (ovf) e_so = 1'b1;
    end
    if (rcr) begin
      if ($signed(r) < 0)  e_cr = 4'b1000;
      else if (r != 0)     e_cr = 4'b0100;
      else                 e_cr = 4'b0010;
      e_cr[0] = e_so;
    end
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check(tag, "res_valid", {31'd0, res_valid}, 32'd1);
    check(tag, "res_data", res_data, r);
    check_flags(tag);
  endtask

  task automatic t_reset();
    check("R10", "res_valid", {31'd0, res_valid}, 32'd0);
    check_flags("R10");
  endtask

  task automatic t_results();
    do_op("R1", 2'd0, 0, 0, 32'd7, 32'd5);
    do_op("R1", 2'd3, 0, 0, 32'd5, 32'd7);
    do_op("R1", 2'd0, 0, 0, 32'hFFFF_FFFF, 32'd2);
  endtask

  task automatic t_cond();
    do_op("R2", 2'd0, 0, 1, 32'd3, 32'd4);
    do_op("R2", 2'd3, 0, 1, 32'd3, 32'd4);
    do_op("R2", 2'd3, 0, 1, 32'h1234, 32'h1234);
  endtask

  task automatic t_add_ovf();
    // The first overflow is seen in cr[0] on the same operation.
    do_op("R3", 2'd0, 1, 1, 32'h7FFF_FFFF, 32'd1);
    do_op("R4", 2'd0, 1, 0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub_ovf();
    do_op("R5", 2'd3, 1, 0, 32'h8000_0000, 32'd1);
    do_op("R5", 2'd3, 1, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_ov_clear();
    do_op("R6", 2'd0, 1, 1, 32'd1, 32'd1);
    do_op("R6", 2'd3, 1, 0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_no_record();
    do_op("R7", 2'd0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    do_op("R7", 2'd2, 0, 0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_carry();
    do_op("R8", 2'd1, 0, 0, 32'hFFFF_FFFF, 32'd1);
    do_op("R8", 2'd0, 0, 0, 32'd1, 32'd1);
    do_op("R8", 2'd3, 0, 0, 32'd0, 32'd1);
    do_op("R8", 2'd1, 0, 0, 32'd1, 32'd1);
  endtask

  task automatic t_extended();
    do_op("R9", 2'd1, 0, 0, 32'h8000_0000, 32'h8000_0000);
    do_op("R9", 2'd2, 0, 1, 32'd0, 32'hFFFF_FFFF);
    do_op("R9", 2'd2, 0, 0, 32'd10, 32'd20);
    do_op("R9", 2'd2, 1, 1, 32'hFFFF_FFF0, 32'h20);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_code = 2'd1; rec_ov = 1; rec_cr = 1;
    opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    check("R11", "res_valid", {31'd0, res_valid}, 32'd0);
    check_flags("R11");
  endtask

  task automatic t_reset_again();
    do_op("R10", 2'd0, 1, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_ca = 0; e_ov = 0; e_so = 0; e_cr = 0;
    t_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_results();
    t_cond();
    t_add_ovf();
    t_sub_ovf();
    t_ov_clear();
    t_no_record();
    t_carry();
    t_extended();
    t_idle();
    t_reset_again();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule